// File: doc/BRIEF.md
# Illegal Instruction Exception Sequencer

This controller sits beside the decode stage of a small 32-bit processor and turns a bad decode into an exception entry. It sorts each decoded instruction into one of three bins. An instruction that changes the program counter, or whose opcode is undefined, is a slot fault when it sits in the shadow of a delayed branch. An undefined opcode anywhere else is a general fault. Every other instruction is left alone. When the block sees a fault, it freezes the pipeline and builds an exception frame on a stack that grows toward lower addresses. It then loads the handler address from a vector table and hands that address to fetch as an immediate jump.

When the fault is detected, the block captures the status word, the stack pointer, the vector table base and the return address. For a slot fault the return address is the pending target of the delayed branch. For a general fault it is the address of the undefined opcode. The frame is written through a valid/ready write port: the status word goes first, at SP-4, and the return address goes second, at SP-8. The handler address is then read through a valid/ready read port from base + 4 × vector number. Vector 6 serves slot faults and vector 4 serves general faults. The new PC and the new SP (SP-8) are presented in the same cycle as the read handshake.

Top module: `illegal_op_entry`

## Requirements
- R1: While reset is active, stall, mem_wr_valid, mem_rd_valid, pc_load and sp_load stay low, even when a faulting decode is presented.
- R2: With dec_valid high and dec_in_slot high, dec_undef or dec_pc_mod (or both) starts a slot-fault entry that uses vector 6. This holds when dec_undef and dec_pc_mod are high together.
- R3: With dec_valid high, dec_in_slot low and dec_undef high, a general-fault entry starts that uses vector 4.
- R4: No entry starts in either of two cases: dec_valid is low, or dec_in_slot and dec_undef are both low. The second case holds even when dec_pc_mod is high. In both cases stall stays low and no memory request appears.
- R5: The first write of an entry goes to SP-4 with SR as data, and the second goes to SP-8. The vector read comes only after both writes.
- R6: The data of the second write is br_target for a slot fault and cur_pc for a general fault.
- R7: The vector read address is vec_base + 4 × vector number.
- R8: In the cycle of the read handshake, pc_load and sp_load pulse for exactly one cycle, with pc_new = mem_rd_data and sp_new = SP-8.
- R9: stall is high in the detection cycle itself and in every cycle up to and including the completion cycle. It is low in the cycle after completion. Its length is therefore 1 + the cycles of the three accesses.
- R10: A request whose ready is low keeps its valid, address and data unchanged until it is accepted.
- R11: Decode flags and all data inputs presented after the detection cycle have no effect on the entry in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is decoded this cycle |
| dec_in_slot | input | 1 | Decoded instruction sits in a delayed-branch slot |
| dec_undef | input | 1 | Opcode is undefined |
| dec_pc_mod | input | 1 | Instruction writes the PC |
| cur_pc | input | 32 | Address of the decoded instruction |
| br_target | input | 32 | Target of the pending delayed branch |
| sr_val | input | 32 | Current status register |
| sp_val | input | 32 | Current stack pointer |
| vec_base | input | 32 | Vector table base address |
| stall | output | 1 | Freeze the pipeline |
| mem_wr_valid | output | 1 | Stack write request |
| mem_wr_ready | input | 1 | Stack write accepted |
| mem_wr_addr | output | 32 | Stack write address |
| mem_wr_data | output | 32 | Stack write data |
| mem_rd_valid | output | 1 | Vector read request |
| mem_rd_ready | input | 1 | Vector read accepted, data valid |
| mem_rd_addr | output | 32 | Vector read address |
| mem_rd_data | input | 32 | Handler address returned |
| pc_load | output | 1 | Load pc_new into the PC now |
| pc_new | output | 32 | Handler address |
| sp_load | output | 1 | Load sp_new into SP now |
| sp_new | output | 32 | Stack pointer after the frame |

## Verification
The hardest situation to reach is R11: a sequence running while decode keeps offering new faults and the captured inputs change. It only arises when an entry is already in flight and the memory is holding off the handshakes. The stimulus reaches it by driving a fresh faulting decode with different SP, SR, PC, target and base values on every cycle after detection. This is combined with ready held back by 0, 1 and 2 cycles, which also exercises R10. The sweep covers all sixteen combinations of the four decode flags under each ready delay.

// File: rtl/illx_pkg.sv
package illx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PUSH_SR = 2'd1,
    ST_PUSH_PC = 2'd2,
    ST_FETCH   = 2'd3
  } illx_state_e;
endpackage

// File: rtl/illx_classify.sv
module illx_classify (
  input  logic dec_valid_i,
  input  logic dec_in_slot_i,
  input  logic dec_undef_i,
  input  logic dec_pc_mod_i,
  output logic fire_o,
  output logic slot_o
);
  logic slot_fault;
  logic gen_fault;

  // A slot fault outranks a general fault; the two cannot coexist here anyway
  always_comb begin
    slot_fault = dec_in_slot_i & (dec_undef_i | dec_pc_mod_i);
    gen_fault  = ~dec_in_slot_i & dec_undef_i;
    fire_o     = dec_valid_i & (slot_fault | gen_fault);
    slot_o     = dec_valid_i & slot_fault;
  end
endmodule

// File: rtl/illx_ctrl.sv
module illx_ctrl
  import illx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fire_i,
  input  logic        wr_ready_i,
  input  logic        rd_ready_i,
  output illx_state_e state_o,
  output logic        cap_en_o,
  output logic        wr_valid_o,
  output logic        rd_valid_o,
  output logic        done_o,
  output logic        stall_o
);
  illx_state_e state_q, state_d;
  logic        accept;

  always_comb begin
    accept  = fire_i & rst_ni & (state_q == ST_IDLE);
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (accept)     state_d = ST_PUSH_SR;
      ST_PUSH_SR: if (wr_ready_i) state_d = ST_PUSH_PC;
      ST_PUSH_PC: if (wr_ready_i) state_d = ST_FETCH;
      ST_FETCH:   if (rd_ready_i) state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_o    = state_q;
    cap_en_o   = accept;
    wr_valid_o = (state_q == ST_PUSH_SR) | (state_q == ST_PUSH_PC);
    rd_valid_o = (state_q == ST_FETCH);
    done_o     = (state_q == ST_FETCH) & rd_ready_i;
    stall_o    = accept | (state_q != ST_IDLE);
  end

  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> wr_valid_o); // R10
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> rd_valid_o); // R10
  AST_STALL_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o || rd_valid_o) |-> stall_o); // R9
endmodule

// File: rtl/illx_frame.sv
module illx_frame
  import illx_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4,
  parameter int VEC_GEN    = 4,
  parameter int VEC_SLOT   = 6
) (
  input  logic            clk_i,
  input  logic            cap_en_i,
  input  logic            slot_i,
  input  illx_state_e     state_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic [XLEN-1:0] br_tgt_i,
  input  logic [XLEN-1:0] sr_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] vbase_i,
  output logic [XLEN-1:0] wr_addr_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic [XLEN-1:0] rd_addr_o,
  output logic [XLEN-1:0] sp_final_o
);
  localparam int              SHIFT    = $clog2(WORD_BYTES);
  localparam logic [XLEN-1:0] STEP     = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] OFF_GEN  = XLEN'(VEC_GEN) << SHIFT;
  localparam logic [XLEN-1:0] OFF_SLOT = XLEN'(VEC_SLOT) << SHIFT;

  logic [XLEN-1:0] sp_q, sr_q, ret_q, vaddr_q;
  logic [XLEN-1:0] ret_d, vaddr_d;

  always_comb begin
    ret_d   = slot_i ? br_tgt_i : cur_pc_i;
    vaddr_d = vbase_i + (slot_i ? OFF_SLOT : OFF_GEN);
  end

  always_ff @(posedge clk_i) begin
    if (cap_en_i) begin
      sp_q    <= sp_i;
      sr_q    <= sr_i;
      ret_q   <= ret_d;
      vaddr_q <= vaddr_d;
    end
  end

  always_comb begin
    if (state_i == ST_PUSH_PC) begin
      wr_addr_o = sp_q - (STEP << 1);
      wr_data_o = ret_q;
    end else begin
      wr_addr_o = sp_q - STEP;
      wr_data_o = sr_q;
    end
    rd_addr_o  = vaddr_q;
    sp_final_o = sp_q - (STEP << 1);
  end
endmodule

// File: rtl/illegal_op_entry.sv
module illegal_op_entry
  import illx_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4,
  parameter int VEC_GEN    = 4,
  parameter int VEC_SLOT   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic            dec_in_slot,
  input  logic            dec_undef,
  input  logic            dec_pc_mod,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] br_target,
  input  logic [XLEN-1:0] sr_val,
  input  logic [XLEN-1:0] sp_val,
  input  logic [XLEN-1:0] vec_base,
  output logic            stall,
  output logic            mem_wr_valid,
  input  logic            mem_wr_ready,
  output logic [XLEN-1:0] mem_wr_addr,
  output logic [XLEN-1:0] mem_wr_data,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [XLEN-1:0] mem_rd_addr,
  input  logic [XLEN-1:0] mem_rd_data,
  output logic            pc_load,
  output logic [XLEN-1:0] pc_new,
  output logic            sp_load,
  output logic [XLEN-1:0] sp_new
);
  localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

  logic [1:0]  rst_sync_q;
  logic        rst_s_n;
  logic        fire, slot, cap_en, done;
  illx_state_e state;

  // Reset asserts asynchronously and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  illx_classify u_classify (
    .dec_valid_i   (dec_valid),
    .dec_in_slot_i (dec_in_slot),
    .dec_undef_i   (dec_undef),
    .dec_pc_mod_i  (dec_pc_mod),
    .fire_o        (fire),
    .slot_o        (slot)
  );

  illx_ctrl u_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_s_n),
    .fire_i     (fire),
    .wr_ready_i (mem_wr_ready),
    .rd_ready_i (mem_rd_ready),
    .state_o    (state),
    .cap_en_o   (cap_en),
    .wr_valid_o (mem_wr_valid),
    .rd_valid_o (mem_rd_valid),
    .done_o     (done),
    .stall_o    (stall)
  );

  illx_frame #(
    .XLEN       (XLEN),
    .WORD_BYTES (WORD_BYTES),
    .VEC_GEN    (VEC_GEN),
    .VEC_SLOT   (VEC_SLOT)
  ) u_frame (
    .clk_i      (clk),
    .cap_en_i   (cap_en),
    .slot_i     (slot),
    .state_i    (state),
    .cur_pc_i   (cur_pc),
    .br_tgt_i   (br_target),
    .sr_i       (sr_val),
    .sp_i       (sp_val),
    .vbase_i    (vec_base),
    .wr_addr_o  (mem_wr_addr),
    .wr_data_o  (mem_wr_data),
    .rd_addr_o  (mem_rd_addr),
    .sp_final_o (sp_new)
  );

  // Handler address goes straight to fetch in the read handshake cycle
  always_comb begin
    pc_load = done;
    sp_load = done;
    pc_new  = mem_rd_data;
  end

  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_wr_valid && !mem_wr_ready) |=> ($stable(mem_wr_addr) && $stable(mem_wr_data))); // R10
  AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_wr_valid && mem_wr_ready) |=> (!mem_wr_valid || (mem_wr_addr == $past(mem_wr_addr) - STEP))); // R5
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    pc_load |=> !pc_load); // R8
  AST_LOAD_NEEDS_STALL: assert property (@(posedge clk) disable iff (!rst_s_n)
    pc_load |-> (stall && mem_rd_valid)); // R9
endmodule

// File: tb/sim_illegal_op_entry.sv
`timescale 1ns/1ps
module sim_illegal_op_entry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 0, dec_in_slot = 0, dec_undef = 0, dec_pc_mod = 0;
  logic [31:0] cur_pc = 0, br_target = 0, sr_val = 0, sp_val = 0, vec_base = 0;
  logic        stall, mem_wr_valid, mem_rd_valid, pc_load, sp_load;
  logic        mem_wr_ready = 0, mem_rd_ready = 0;
  logic [31:0] mem_wr_addr, mem_wr_data, mem_rd_addr, pc_new, sp_new;
  logic [31:0] mem_rd_data = 0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  illegal_op_entry u0 (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_in_slot(dec_in_slot), .dec_undef(dec_undef), .dec_pc_mod(dec_pc_mod),
    .cur_pc(cur_pc), .br_target(br_target), .sr_val(sr_val), .sp_val(sp_val), .vec_base(vec_base),
    .stall(stall),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .pc_load(pc_load), .pc_new(pc_new), .sp_load(sp_load), .sp_new(sp_new)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] quiet_bits();
    return {27'd0, stall, mem_wr_valid, mem_rd_valid, pc_load, sp_load};
  endfunction

  task automatic run_case(input int idx, input bit v, input bit s, input bit u, input bit m, input int wt);
    logic [31:0] e_sp, e_sr, e_pc, e_bt, e_base, e_hnd, e_ret, e_vaddr;
    bit    trig, is_slot, seen_load, held;
    int    wcnt, rcnt, nwr, stall_cnt, after;
    logic [31:0] last_addr, last_data;
    string ktag;
    e_sp   = 32'h0000_8000 + 32'(idx * 64);
    e_sr   = 32'h5A00_0000 | 32'(idx);
    e_pc   = 32'h0001_0000 + 32'(idx * 2);
    e_bt   = 32'h0002_0000 + 32'(idx * 4);
    e_base = 32'h0000_1000 + 32'(idx * 256);
    e_hnd  = 32'hC000_0000 + 32'(idx * 16);
    is_slot = v && s && (u || m);
    trig    = is_slot || (v && !s && u);
    e_ret   = is_slot ? e_bt : e_pc;
    e_vaddr = e_base + (is_slot ? 32'd24 : 32'd16);
    ktag    = is_slot ? "R2" : (trig ? "R3" : "R4");
    seen_load = 0; held = 0; wcnt = 0; rcnt = 0; nwr = 0; stall_cnt = 0; after = 0;
    last_addr = 0; last_data = 0;

    @(negedge clk);
    dec_valid = v; dec_in_slot = s; dec_undef = u; dec_pc_mod = m;
    cur_pc = e_pc; br_target = e_bt; sr_val = e_sr; sp_val = e_sp; vec_base = e_base;
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (cyc > 0) begin
        @(negedge clk);
        if (trig && !seen_load) begin
          // R11: a fresh faulting decode with different data every busy cycle
          dec_valid = 1; dec_in_slot = cyc[0]; dec_undef = 1; dec_pc_mod = 1;
          cur_pc = 32'hDEAD_0000 + 32'(cyc); br_target = 32'hBEEF_0000 + 32'(cyc);
          sr_val = 32'h1111_0000 + 32'(cyc); sp_val = 32'h7770_0000 + 32'(cyc * 16);
          vec_base = 32'h4440_0000 + 32'(cyc * 256);
        end else begin
          dec_valid = 0; dec_in_slot = 0; dec_undef = 0; dec_pc_mod = 0;
        end
      end
      mem_wr_ready = mem_wr_valid && (wcnt >= wt);
      mem_rd_ready = mem_rd_valid && (rcnt >= wt);
      mem_rd_data  = mem_rd_ready ? e_hnd : 32'h0;
      #1;
      if (cyc == 0) chk(stall == trig, ktag, {31'd0, stall}, {31'd0, trig});
      if (!trig) begin
        chk(quiet_bits() == 32'd0, "R4", quiet_bits(), 32'd0);
        if (cyc >= 4) break;
        continue;
      end
      if (seen_load) begin
        chk(quiet_bits() == 32'd0, "R9", quiet_bits(), 32'd0);
        after++;
        if (after >= 2) break;
        continue;
      end
      if (stall) stall_cnt++;
      else chk(1'b0, "R9", 32'd0, 32'd1);
      if (held && mem_wr_valid)
        chk(mem_wr_addr == last_addr && mem_wr_data == last_data, "R10", mem_wr_addr, last_addr);
      held = 0;
      if (mem_wr_valid) begin
        if (mem_wr_ready) begin
          if (nwr == 0) begin
            chk(mem_wr_addr == e_sp - 32'd4, "R5", mem_wr_addr, e_sp - 32'd4);
            chk(mem_wr_data == e_sr, "R5", mem_wr_data, e_sr);
          end else begin
            chk(mem_wr_addr == e_sp - 32'd8, "R5", mem_wr_addr, e_sp - 32'd8);
            chk(mem_wr_data == e_ret, "R6", mem_wr_data, e_ret);
          end
          nwr++; wcnt = 0;
        end else begin
          wcnt++; held = 1; last_addr = mem_wr_addr; last_data = mem_wr_data;
        end
      end
      if (pc_load && !(mem_rd_valid && mem_rd_ready)) chk(1'b0, "R8", 32'd1, 32'd0);
      if (mem_rd_valid) begin
        chk(nwr == 2, "R5", 32'(nwr), 32'd2);
        chk(mem_rd_addr == e_vaddr, ktag, mem_rd_addr, e_vaddr);
        chk(mem_rd_addr == e_vaddr, "R7", mem_rd_addr, e_vaddr);
        if (mem_rd_ready) begin
          chk(pc_load && sp_load, "R8", {30'd0, pc_load, sp_load}, 32'd3);
          chk(pc_new == e_hnd, "R8", pc_new, e_hnd);
          chk(sp_new == e_sp - 32'd8, "R8", sp_new, e_sp - 32'd8);
          seen_load = 1;
        end else begin
          chk(!pc_load, "R8", {31'd0, pc_load}, 32'd0);
          chk(mem_rd_addr == e_vaddr, "R10", mem_rd_addr, e_vaddr);
          rcnt++;
        end
      end
    end
    if (trig) begin
      chk(seen_load, "R8", {31'd0, seen_load}, 32'd1);
      chk(stall_cnt == 1 + 3 * (wt + 1), "R9", 32'(stall_cnt), 32'(1 + 3 * (wt + 1)));
      chk(nwr == 2, "R11", 32'(nwr), 32'd2);
    end
    @(negedge clk);
    mem_wr_ready = 0; mem_rd_ready = 0;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: faulting decode offered while reset is held
    dec_valid = 1; dec_undef = 1; dec_in_slot = 1; sp_val = 32'h100;
    repeat (3) begin
      @(negedge clk); #1;
      chk(quiet_bits() == 32'd0, "R1", quiet_bits(), 32'd0);
    end
    dec_valid = 0; dec_undef = 0; dec_in_slot = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(quiet_bits() == 32'd0, "R1", quiet_bits(), 32'd0);
    for (int wt = 0; wt < 3; wt++)
      for (int f = 0; f < 16; f++)
        run_case(wt * 16 + f, f[3], f[2], f[1], f[0], wt);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule